// File: doc/BRIEF.md
# Divide Step Unit

This block performs one step of non-restoring binary division per accepted command. It keeps three status bits between commands. Q holds the quotient-sign history. M holds the divisor sign. T holds the step outcome. Software or a sequencer outside the block chains the commands into a full division.

A setup command prepares the status bits. Signed setup loads them from the operand signs, and unsigned setup clears them. Each step command takes the partial remainder and the divisor as inputs and returns the updated remainder. A full quotient needs 32 steps, with the quotient bits rotated through T outside the block. Loop control and final quotient correction happen outside the block.

Commands arrive on a valid/ready interface, and results leave on a second valid/ready interface. A command is accepted in a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low only while a result is waiting and `res_ready` is low. A result stays valid and unchanged until `res_ready` takes it. The status bits are plain outputs.

Top module: `divstep_unit`

## Requirements
- R1: After reset, `res_valid`, `res_rem`, `flag_q`, `flag_m` and `flag_t` are all 0, and `cmd_ready` is 1.
- R2: Signed setup (`cmd_op` = 2'b01) sets Q to the MSB of `cmd_rem`, M to the MSB of `cmd_div`, and T to Q XOR M, and returns `cmd_rem` unchanged as the result.
- R3: Unsigned setup (`cmd_op` = 2'b10) clears Q, M and T, and returns `cmd_rem` unchanged.
- R4: A step (`cmd_op` = 2'b00) first shifts `cmd_rem` left by one with the current T in bit 0. It then subtracts `cmd_div` from the shifted value when the current Q equals M, and adds it otherwise. The result, modulo 2^WIDTH, is the returned remainder.
- R5: After a step, Q is the XOR of three bits: the bit shifted out of the MSB, the carry or borrow of the add or subtract, and M.
- R6: After a step, T is 1 exactly when the new Q equals M.
- R7: A step leaves M unchanged.
- R8: The result of an accepted command is valid on the clock edge that accepts it, which means one cycle of latency. `cmd_ready` equals `!res_valid || res_ready`.
- R9: While `res_valid` is high and `res_ready` is low, no command is accepted and `res_rem`, Q, M and T hold their values.
- R10: The reserved code `cmd_op` = 2'b11 leaves Q, M and T unchanged and returns `cmd_rem` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 2 | 00 step, 01 signed setup, 10 unsigned setup, 11 reserved |
| cmd_rem | input | WIDTH | Partial remainder (the dividend for setup) |
| cmd_div | input | WIDTH | Divisor |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result taken |
| res_rem | output | WIDTH | Updated remainder |
| flag_q | output | 1 | Q status bit |
| flag_m | output | 1 | M status bit |
| flag_t | output | 1 | T status bit |

## Verification
The bench builds the unit with WIDTH = 32, the width the step is defined for. At that width the carry out of bit 31 and the borrow from an all-ones divisor both occur, and all four Q/M combinations are reached through both setups. The reference model forms the carry from a 33-bit sum and the borrow from a direct comparison, so it shares no logic with the design. Random gaps on `res_ready` hold results waiting while new commands are offered, which exercises back-pressure and shows that the flags stay frozen.

// File: rtl/divstep_pkg.sv
package divstep_pkg;
  typedef enum logic [1:0] {
    OP_STEP    = 2'b00,
    OP_SETUP_S = 2'b01,
    OP_SETUP_U = 2'b10,
    OP_RSV     = 2'b11
  } ds_op_e;
endpackage

// File: rtl/divstep_alu.sv
module divstep_alu
  import divstep_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  ds_op_e           op_i,
  input  logic [WIDTH-1:0] rem_i,
  input  logic [WIDTH-1:0] div_i,
  input  logic             q_i,
  input  logic             m_i,
  input  logic             t_i,
  output logic [WIDTH-1:0] rem_o,
  output logic             q_o,
  output logic             m_o,
  output logic             t_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] combined;
  logic             out_bit;
  logic             subtract;
  logic             cy;

  assign out_bit  = rem_i[MSB];
  assign shifted  = {rem_i[MSB-1:0], t_i};
  assign subtract = (q_i == m_i);
  assign combined = subtract ? (shifted - div_i) : (shifted + div_i);
  // borrow: result grew; carry: result wrapped below the operand
  assign cy       = subtract ? (combined > shifted) : (combined < shifted);

  always_comb begin
    rem_o = rem_i;
    q_o   = q_i;
    m_o   = m_i;
    t_o   = t_i;
    unique case (op_i)
      OP_STEP: begin
        rem_o = combined;
        q_o   = out_bit ^ cy ^ m_i;
        t_o   = ((out_bit ^ cy ^ m_i) == m_i);
      end
      OP_SETUP_S: begin
        q_o = rem_i[MSB];
        m_o = div_i[MSB];
        t_o = rem_i[MSB] ^ div_i[MSB];
      end
      OP_SETUP_U: begin
        q_o = 1'b0;
        m_o = 1'b0;
        t_o = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/divstep_flags.sv
module divstep_flags
  import divstep_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_i,
  input  ds_op_e op_i,
  input  logic   q_d,
  input  logic   m_d,
  input  logic   t_d,
  output logic   q_o,
  output logic   m_o,
  output logic   t_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= 1'b0;
      m_o <= 1'b0;
      t_o <= 1'b0;
    end else if (load_i) begin
      q_o <= q_d;
      m_o <= m_d;
      t_o <= t_d;
    end
  end

  assert_t_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && op_i == OP_STEP |=> t_o == (q_o == m_o));
  assert_m_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && op_i == OP_STEP |=> $stable(m_o));
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && op_i == OP_SETUP_U |=> !q_o && !m_o && !t_o);
  assert_rsv_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && op_i == OP_RSV |=> $stable({q_o, m_o, t_o}));
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable({q_o, m_o, t_o}));
endmodule

// File: rtl/divstep_out.sv
module divstep_out #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_rem,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [WIDTH-1:0] res_rem
);
  assign in_ready = !res_valid || res_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_rem   <= '0;
    end else if (in_valid && in_ready) begin
      res_valid <= 1'b1;
      res_rem   <= in_rem;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> res_valid);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_rem));
endmodule

// File: rtl/divstep_unit.sv
module divstep_unit
  import divstep_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [WIDTH-1:0] cmd_rem,
  input  logic [WIDTH-1:0] cmd_div,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [WIDTH-1:0] res_rem,
  output logic             flag_q,
  output logic             flag_m,
  output logic             flag_t
);
  ds_op_e           op;
  logic             fire;
  logic [WIDTH-1:0] next_rem;
  logic             next_q, next_m, next_t;

  assign op   = ds_op_e'(cmd_op);
  assign fire = cmd_valid && cmd_ready;

  divstep_alu #(.WIDTH(WIDTH)) u_alu (
    .op_i (op),
    .rem_i(cmd_rem),
    .div_i(cmd_div),
    .q_i  (flag_q),
    .m_i  (flag_m),
    .t_i  (flag_t),
    .rem_o(next_rem),
    .q_o  (next_q),
    .m_o  (next_m),
    .t_o  (next_t)
  );

  divstep_flags u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(fire),
    .op_i  (op),
    .q_d   (next_q),
    .m_d   (next_m),
    .t_d   (next_t),
    .q_o   (flag_q),
    .m_o   (flag_m),
    .t_o   (flag_t)
  );

  divstep_out #(.WIDTH(WIDTH)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (cmd_valid),
    .in_ready (cmd_ready),
    .in_rem   (next_rem),
    .res_valid(res_valid),
    .res_ready(res_ready),
    .res_rem  (res_rem)
  );

  assert_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op == OP_SETUP_S |=> flag_t == (flag_q ^ flag_m) && res_rem == $past(cmd_rem));
endmodule

// File: tb/tb_divstep_unit.sv
module tb_divstep_unit;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [1:0]   cmd_op = 2'b00;
  logic [W-1:0] cmd_rem = '0;
  logic [W-1:0] cmd_div = '0;
  logic         res_valid;
  logic         res_ready = 1'b1;
  logic [W-1:0] res_rem;
  logic         flag_q, flag_m, flag_t;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  divstep_unit #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_rem(cmd_rem), .cmd_div(cmd_div),
    .res_valid(res_valid), .res_ready(res_ready), .res_rem(res_rem),
    .flag_q(flag_q), .flag_m(flag_m), .flag_t(flag_t)
  );

  // reference model
  bit         mq = 0, mm = 0, mt = 0, mv = 0;
  bit [W-1:0] mrem = '0;
  string      lrem = "R1", lq = "R1", lm = "R1", lt = "R1";

  always @(posedge clk) begin
    if (rst_n) begin
      if (cmd_valid && (!mv || res_ready)) begin
        case (cmd_op)
          2'b00: begin
            bit [W:0] s;
            bit [W-1:0] sh;
            bit sb, c;
            sb = cmd_rem[W-1];
            sh = (cmd_rem << 1) | W'(mt);
            if (mq == mm) begin
              c = (sh < cmd_div);
              mrem = sh - cmd_div;
            end else begin
              s = {1'b0, sh} + {1'b0, cmd_div};
              c = s[W];
              mrem = s[W-1:0];
            end
            mq = sb ^ c ^ mm;
            mt = (mq == mm);
            lrem = "R4"; lq = "R5"; lm = "R7"; lt = "R6";
          end
          2'b01: begin
            mq = cmd_rem[W-1]; mm = cmd_div[W-1]; mt = mq ^ mm; mrem = cmd_rem;
            lrem = "R2"; lq = "R2"; lm = "R2"; lt = "R2";
          end
          2'b10: begin
            mq = 0; mm = 0; mt = 0; mrem = cmd_rem;
            lrem = "R3"; lq = "R3"; lm = "R3"; lt = "R3";
          end
          default: begin
            mrem = cmd_rem;
            lrem = "R10"; lq = "R10"; lm = "R10"; lt = "R10";
          end
        endcase
        mv = 1;
      end else begin
        if (mv && !res_ready) begin
          lrem = "R9"; lq = "R9"; lm = "R9"; lt = "R9";
        end
        if (res_ready) mv = 0;
      end
    end
  end

  task automatic chk(string r, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R8", W'(res_valid), W'(mv));
    chk("R8", W'(cmd_ready), W'(!mv || res_ready));
    if (mv) chk(lrem, res_rem, mrem);
    chk(lq, W'(flag_q), W'(mq));
    chk(lm, W'(flag_m), W'(mm));
    chk(lt, W'(flag_t), W'(mt));
  endtask

  task automatic cyc(bit v, bit [1:0] op, bit [W-1:0] r, bit [W-1:0] d, bit rdy);
    @(negedge clk);
    compare();
    cmd_valid = v; cmd_op = op; cmd_rem = r; cmd_div = d; res_ready = rdy;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", W'(res_valid), 0);
    chk("R1", res_rem, 0);
    chk("R1", W'({flag_q, flag_m, flag_t}), 0);
    chk("R1", W'(cmd_ready), 1);
    rst_n = 1'b1;
    // R2: signed setups over all sign pairs, then steps
    for (int s = 0; s < 4; s++) begin
      cyc(1, 2'b01, s[1] ? 32'hF000_0123 : 32'h0000_0456, s[0] ? 32'hFFFF_FFF9 : 32'h0000_0007, 1);
      for (int k = 0; k < 6; k++)
        cyc(1, 2'b00, 32'h8000_0000 >> k ^ 32'h1234_5678 * k, s[0] ? 32'hFFFF_FFF9 : 32'h0000_0007, 1);
    end
    // R3: unsigned setup then steps with edge divisors
    cyc(1, 2'b10, 32'hDEAD_BEEF, 32'h8000_0001, 1);
    cyc(1, 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);
    cyc(1, 2'b00, 32'h8000_0000, 32'h0000_0000, 1);
    cyc(1, 2'b00, 32'h7FFF_FFFF, 32'h0000_0001, 1);
    cyc(1, 2'b00, 32'h0000_0000, 32'hFFFF_FFFF, 1);
    // R10: reserved code after signed setup
    cyc(1, 2'b01, 32'h8000_0000, 32'h0000_0001, 1);
    cyc(1, 2'b11, 32'hCAFE_F00D, 32'h1111_1111, 1);
    cyc(1, 2'b00, 32'h4000_0000, 32'h0000_0003, 1);
    // R9: back-pressure with commands offered
    cyc(1, 2'b00, 32'h1357_9BDF, 32'h0000_0005, 0);
    cyc(1, 2'b01, 32'hFFFF_0000, 32'hFFFF_0000, 0);
    cyc(1, 2'b10, 32'h0, 32'h0, 0);
    cyc(1, 2'b00, 32'h2468_ACE0, 32'h0000_0009, 1);
    cyc(0, 2'b00, 32'h0, 32'h0, 1);
    cyc(0, 2'b00, 32'h0, 32'h0, 0);
    // random mix with random back-pressure
    for (int i = 0; i < 400; i++)
      cyc($urandom_range(0, 3) != 0, 2'($urandom_range(0, 9) < 7 ? 0 : $urandom_range(1, 3)),
          $urandom, ($urandom_range(0, 5) == 0) ? 32'hFFFF_FFFF : $urandom,
          $urandom_range(0, 3) != 0);
    cyc(0, 2'b00, 0, 0, 1);
    cyc(0, 2'b00, 0, 0, 1);
    @(negedge clk);
    compare();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule